// File: doc/BRIEF.md
# I2C Master Transfer Length Controller

This block sequences a single I2C master transfer on top of a byte-level bus engine. Software presents a target address, an addressing width (7 or 10 bits), a direction, a byte count of up to 255, a chunk-chaining enable and an automatic-STOP enable, then pulses a start request. The controller issues START and the address phase. It then moves data bytes through a transmit-request / write handshake or a receive-ready / read handshake, and counts the bytes down to zero.

When a count runs out, the controller does one of three things. It can pause with a reload flag set until a fresh count arrives, and then carry on with no START and no address. It can end with STOP by itself. Or it can park with a transfer-complete flag set until software asks for STOP or a repeated START. A NACK from the target ends the transfer with STOP. Arbitration loss and bus errors drop the controller to idle without STOP. All abnormal events leave sticky flags that software clears with a per-flag clear bit.

The bus engine below accepts one command at a time on `eng_cmd` while `eng_cmd_valid` is high. It answers with a one-cycle `eng_done`, or with `eng_arb_lost` / `eng_bus_err` in place of `eng_done`.

Top module: `i2cx_xfer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `txis`, `rxne`, `tc`, `tcr`, all five sticky flags and `eng_cmd_valid` are 0.
- R2: Engine commands are coded on `eng_cmd` as 0 = START, 1 = WRITE byte, 2 = READ byte, 3 = STOP. A transfer starts with START followed by a WRITE of the address byte. In 7-bit mode that byte is `{addr[6:0], dir}`, where dir 1 means read.
- R3: In a write transfer, `txis` is high while the controller waits for a byte. Each `tx_wr` pulse hands `tx_data` to exactly one WRITE command, and exactly the programmed number of data bytes is written.
- R4: In a read transfer, each byte received is placed on `rx_data` with `rxne` set, and a `rx_rd` pulse clears `rxne`. Every READ command has `eng_ack_out` = 0 (ACK), except the final byte of a chunk with reload disabled, which has `eng_ack_out` = 1 (NACK).
- R5: When the count runs out with reload and automatic STOP both disabled, `tc` is set, `busy` stays high and no command is issued. A later `stop_req` issues STOP. A later `start_req` instead latches a new configuration and issues a repeated START.
- R6: When the count runs out with reload enabled, `tcr` is set and no command is issued until `nbytes_load`. That pulse loads `cfg_nbytes`, `cfg_reload` and `cfg_autoend`, and data transfer resumes with no START and no address byte.
- R7: When the count runs out with reload disabled and automatic STOP enabled, STOP is issued without software action and `tc` is never set.
- R8: A NACK returned for an address byte or a written data byte sets `nack_flag`, and the next command is STOP. No further data byte is requested.
- R9: Completion of STOP sets `stop_flag`, clears `busy` and clears the latched reload enable.
- R10: A byte count of zero produces only START and the address phase, followed by the normal end-of-chunk behaviour.
- R11: If a byte is received while `rxne` is still set and it is not being read in the same cycle, `ovr_flag` is set and `rx_data` takes the new byte.
- R12: In 10-bit mode the address phase writes `{5'b11110, addr[9:8], 0}` and then `addr[7:0]`. For a read, it follows these with a repeated START and `{5'b11110, addr[9:8], 1}`.
- R13: Arbitration loss or bus error sets `arlo_flag` or `berr_flag`, and the controller returns to idle with no STOP. Sticky flags are cleared by `flag_clr` bits: 0 = NACK, 1 = STOP, 2 = arbitration, 3 = bus error, 4 = overrun. A flag stays set until its clear bit is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 10 | Target address (7-bit mode uses bits 6:0) |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_read | input | 1 | 1 = read transfer, 0 = write |
| cfg_nbytes | input | CW | Byte count for the next chunk |
| cfg_reload | input | 1 | Chunk is followed by another chunk of the same transfer |
| cfg_autoend | input | 1 | Issue STOP automatically after the last byte |
| start_req | input | 1 | Pulse: start (or restart) a transfer |
| stop_req | input | 1 | Pulse: request STOP while transfer-complete |
| nbytes_load | input | 1 | Pulse: load a new chunk count while reload-paused |
| tx_data | input | 8 | Next byte to transmit |
| tx_wr | input | 1 | Pulse: `tx_data` is valid |
| rx_data | output | 8 | Last received byte |
| rx_rd | input | 1 | Pulse: `rx_data` consumed |
| flag_clr | input | 5 | Clear bits for the sticky flags |
| busy | output | 1 | Transfer in progress |
| txis | output | 1 | Transmit byte requested |
| rxne | output | 1 | Received byte waiting |
| tc | output | 1 | Chunk finished, waiting for STOP or restart |
| tcr | output | 1 | Chunk finished, waiting for a reload count |
| nack_flag | output | 1 | Sticky: target NACKed |
| stop_flag | output | 1 | Sticky: STOP completed |
| arlo_flag | output | 1 | Sticky: arbitration lost |
| berr_flag | output | 1 | Sticky: bus error |
| ovr_flag | output | 1 | Sticky: receive overrun |
| eng_cmd_valid | output | 1 | Command to the bus engine is valid |
| eng_cmd | output | 2 | Command code (see R2) |
| eng_wdata | output | 8 | Byte for a WRITE command |
| eng_ack_out | output | 1 | Acknowledge to send after a READ (1 = NACK) |
| eng_done | input | 1 | Engine finished the current command |
| eng_rdata | input | 8 | Byte returned by a READ |
| eng_nack | input | 1 | Target NACKed the WRITE just finished |
| eng_arb_lost | input | 1 | Arbitration lost (replaces done) |
| eng_bus_err | input | 1 | Misplaced START/STOP seen (replaces done) |

## Verification
The hardest situation to reach is a reload pause in the middle of a write. Here the controller must sit with `tcr` high and the bus held, then take a new count and continue with a single data byte and an automatic STOP. The stimulus programs a two-byte chunk with reload set and idles several cycles to show that no command leaks out. It then loads a count of one with reload cleared and automatic STOP set, while the bench's engine model checks that no START or address byte appears between the chunks. Overrun is reached by withholding `rx_rd` across two received bytes. NACK, arbitration loss and bus error are injected on a chosen command number in the engine model.

// File: rtl/i2cx_pkg.sv
// Shared types for the I2C master transfer length controller.
package i2cx_pkg;

    // Command codes presented to the byte-level bus engine.
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } eng_cmd_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADR_HI,
        S_ADR_LO,
        S_RESTART,
        S_ADR_RD,
        S_DECIDE,
        S_TXWAIT,
        S_TXBYTE,
        S_RXBYTE,
        S_TCWAIT,
        S_RLWAIT,
        S_STOP
    } seq_state_e;

    // Sticky flag positions, shared by the flag bank and the clear vector.
    localparam int FL_NACK = 0;
    localparam int FL_STOP = 1;
    localparam int FL_ARLO = 2;
    localparam int FL_BERR = 3;
    localparam int FL_OVR  = 4;
    localparam int NFLAG   = 5;

    localparam int DW = 8;   // data byte width
    localparam int AW = 10;  // widest address

endpackage

// File: rtl/i2cx_byte_count.sv
// Down-counter for the bytes left in the current chunk.
// Assumes load and dec are never asserted in the same cycle.
module i2cx_byte_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] count;

    // Load a fresh chunk size or count one byte off.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= load_val;
        else if (dec)     count <= count - ONE;
    end

    assign is_zero = (count == '0);
    assign is_one  = (count == ONE);
endmodule

// File: rtl/i2cx_status.sv
// Sticky event flags and the receive holding register.
// Assumes an event and its clear bit in the same cycle resolve to set.
module i2cx_status
    import i2cx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_nack,
    input  logic             ev_stop,
    input  logic             ev_arlo,
    input  logic             ev_berr,
    input  logic             rx_cap,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rx_rd,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] sticky,
    output logic             rxne,
    output logic [DW-1:0]    rx_data
);
    logic [NFLAG-1:0] ev;

    // Gather the set events in flag-index order.
    always_comb begin
        ev          = '0;
        ev[FL_NACK] = ev_nack;
        ev[FL_STOP] = ev_stop;
        ev[FL_ARLO] = ev_arlo;
        ev[FL_BERR] = ev_berr;
        ev[FL_OVR]  = rx_cap && rxne && !rx_rd;
    end

    // One set-dominant sticky bit per flag.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) sticky[i] <= 1'b0;
            else        sticky[i] <= ev[i] | (sticky[i] & ~clr[i]);
        end
    end

    // Hold the last received byte and its not-empty status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxne    <= 1'b0;
            rx_data <= '0;
        end else if (rx_cap) begin
            rxne    <= 1'b1;
            rx_data <= rx_byte;
        end else if (rx_rd) begin
            rxne    <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cx_seq.sv
// Transfer sequencer: START, address phase, byte loop, end-of-chunk choice.
// Assumes the engine answers each command with exactly one of done,
// arb_lost or bus_err, and that arb_lost / bus_err only occur while busy.
module i2cx_seq
    import i2cx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_ten_bit,
    input  logic          cfg_read,
    input  logic          cfg_reload,
    input  logic          cfg_autoend,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          nbytes_load,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_wr,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          eng_arb_lost,
    input  logic          eng_bus_err,
    input  logic          cnt_zero,
    input  logic          cnt_one,
    output logic          cnt_load,
    output logic          cnt_dec,
    output logic          ev_nack,
    output logic          ev_stop,
    output logic          ev_arlo,
    output logic          ev_berr,
    output logic          rx_cap,
    output logic          busy,
    output logic          txis,
    output logic          tc,
    output logic          tcr,
    output logic          eng_cmd_valid,
    output logic [1:0]    eng_cmd,
    output logic [DW-1:0] eng_wdata,
    output logic          eng_ack_out
);
    localparam logic [4:0] HDR10 = 5'b11110;

    seq_state_e    state;
    logic [AW-1:0] l_addr;
    logic          l_ten, l_rd, l_reload, l_autoend;
    logic [DW-1:0] l_wdata;
    logic          aborted, wr_phase, start_go, reload_go, done_ok;

    // Abort and handshake qualifiers.
    always_comb begin
        ev_arlo   = eng_arb_lost && (state != S_IDLE);
        ev_berr   = eng_bus_err && (state != S_IDLE) && !eng_arb_lost;
        aborted   = ev_arlo || ev_berr;
        done_ok   = eng_done && !aborted;
        wr_phase  = (state == S_ADR_HI) || (state == S_ADR_LO) ||
                    (state == S_ADR_RD) || (state == S_TXBYTE);
        start_go  = start_req && !aborted &&
                    ((state == S_IDLE) || (state == S_TCWAIT));
        reload_go = nbytes_load && !aborted && (state == S_RLWAIT);
        ev_nack   = done_ok && eng_nack && wr_phase;
        ev_stop   = done_ok && (state == S_STOP);
        rx_cap    = done_ok && (state == S_RXBYTE);
        cnt_load  = start_go || reload_go;
        cnt_dec   = done_ok && (((state == S_TXBYTE) && !eng_nack) ||
                                 (state == S_RXBYTE));
    end

    // State register and latched transfer settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            l_addr    <= '0;
            l_ten     <= 1'b0;
            l_rd      <= 1'b0;
            l_reload  <= 1'b0;
            l_autoend <= 1'b0;
            l_wdata   <= '0;
        end else if (aborted) begin
            state     <= S_IDLE;
        end else begin
            if (start_go) begin
                l_addr    <= cfg_addr;
                l_ten     <= cfg_ten_bit;
                l_rd      <= cfg_read;
                l_reload  <= cfg_reload;
                l_autoend <= cfg_autoend;
            end
            if (reload_go) begin
                l_reload  <= cfg_reload;
                l_autoend <= cfg_autoend;
            end
            case (state)
                S_IDLE:    if (start_go) state <= S_START;
                S_START:   if (eng_done) state <= S_ADR_HI;
                S_ADR_HI:  if (eng_done)
                               state <= eng_nack ? S_STOP :
                                        (l_ten ? S_ADR_LO : S_DECIDE);
                S_ADR_LO:  if (eng_done)
                               state <= eng_nack ? S_STOP :
                                        (l_rd ? S_RESTART : S_DECIDE);
                S_RESTART: if (eng_done) state <= S_ADR_RD;
                S_ADR_RD:  if (eng_done) state <= eng_nack ? S_STOP : S_DECIDE;
                S_DECIDE:
                    if (!cnt_zero)      state <= l_rd ? S_RXBYTE : S_TXWAIT;
                    else if (l_reload)  state <= S_RLWAIT;
                    else if (l_autoend) state <= S_STOP;
                    else                state <= S_TCWAIT;
                S_TXWAIT:  if (tx_wr) begin
                               l_wdata <= tx_data;
                               state   <= S_TXBYTE;
                           end
                S_TXBYTE:  if (eng_done) state <= eng_nack ? S_STOP : S_DECIDE;
                S_RXBYTE:  if (eng_done) state <= S_DECIDE;
                S_TCWAIT:  if (start_go)      state <= S_START;
                           else if (stop_req) state <= S_STOP;
                S_RLWAIT:  if (reload_go) state <= S_DECIDE;
                S_STOP:    if (eng_done) begin
                               state    <= S_IDLE;
                               l_reload <= 1'b0;
                           end
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Engine command decode and software-visible status.
    always_comb begin
        busy          = (state != S_IDLE);
        txis          = (state == S_TXWAIT);
        tc            = (state == S_TCWAIT);
        tcr           = (state == S_RLWAIT);
        eng_cmd_valid = wr_phase || (state == S_START) || (state == S_RESTART) ||
                        (state == S_RXBYTE) || (state == S_STOP);
        eng_ack_out   = (state == S_RXBYTE) && cnt_one && !l_reload;
        case (state)
            S_START, S_RESTART: eng_cmd = CMD_START;
            S_STOP:             eng_cmd = CMD_STOP;
            S_RXBYTE:           eng_cmd = CMD_READ;
            default:            eng_cmd = CMD_WRITE;
        endcase
        case (state)
            S_ADR_HI: eng_wdata = l_ten ? {HDR10, l_addr[9:8], 1'b0}
                                        : {l_addr[6:0], l_rd};
            S_ADR_LO: eng_wdata = l_addr[7:0];
            S_ADR_RD: eng_wdata = {HDR10, l_addr[9:8], 1'b1};
            S_TXBYTE: eng_wdata = l_wdata;
            default:  eng_wdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cx_xfer_ctrl.sv
// Top level: I2C master transfer length controller.
// Wires the sequencer, the chunk byte counter and the flag bank together.
// Assumes a byte-level engine that handles all bit timing.
module i2cx_xfer_ctrl
    import i2cx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [9:0]    cfg_addr,
    input  logic          cfg_ten_bit,
    input  logic          cfg_read,
    input  logic [CW-1:0] cfg_nbytes,
    input  logic          cfg_reload,
    input  logic          cfg_autoend,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          nbytes_load,
    input  logic [7:0]    tx_data,
    input  logic          tx_wr,
    output logic [7:0]    rx_data,
    input  logic          rx_rd,
    input  logic [4:0]    flag_clr,
    output logic          busy,
    output logic          txis,
    output logic          rxne,
    output logic          tc,
    output logic          tcr,
    output logic          nack_flag,
    output logic          stop_flag,
    output logic          arlo_flag,
    output logic          berr_flag,
    output logic          ovr_flag,
    output logic          eng_cmd_valid,
    output logic [1:0]    eng_cmd,
    output logic [7:0]    eng_wdata,
    output logic          eng_ack_out,
    input  logic          eng_done,
    input  logic [7:0]    eng_rdata,
    input  logic          eng_nack,
    input  logic          eng_arb_lost,
    input  logic          eng_bus_err
);
    logic cnt_load, cnt_dec, cnt_zero, cnt_one;
    logic ev_nack, ev_stop, ev_arlo, ev_berr, rx_cap;
    logic [NFLAG-1:0] sticky;

    i2cx_byte_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cfg_nbytes),
        .dec(cnt_dec), .is_zero(cnt_zero), .is_one(cnt_one)
    );

    i2cx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_ten_bit(cfg_ten_bit),
        .cfg_read(cfg_read), .cfg_reload(cfg_reload), .cfg_autoend(cfg_autoend),
        .start_req(start_req), .stop_req(stop_req), .nbytes_load(nbytes_load),
        .tx_data(tx_data), .tx_wr(tx_wr), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_bus_err(eng_bus_err),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_arlo(ev_arlo), .ev_berr(ev_berr),
        .rx_cap(rx_cap), .busy(busy), .txis(txis), .tc(tc), .tcr(tcr),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
        .eng_ack_out(eng_ack_out)
    );

    i2cx_status u_stat (
        .clk(clk), .rst_n(rst_n), .ev_nack(ev_nack), .ev_stop(ev_stop),
        .ev_arlo(ev_arlo), .ev_berr(ev_berr), .rx_cap(rx_cap), .rx_byte(eng_rdata),
        .rx_rd(rx_rd), .clr(flag_clr), .sticky(sticky), .rxne(rxne), .rx_data(rx_data)
    );

    assign nack_flag = sticky[FL_NACK];
    assign stop_flag = sticky[FL_STOP];
    assign arlo_flag = sticky[FL_ARLO];
    assign berr_flag = sticky[FL_BERR];
    assign ovr_flag  = sticky[FL_OVR];
endmodule

// File: rtl/i2cx_xfer_ctrl_chk.sv
// Protocol checker for i2cx_xfer_ctrl, attached by bind.
module i2cx_xfer_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       stop_req,
    input logic       nbytes_load,
    input logic       tx_wr,
    input logic       busy,
    input logic       txis,
    input logic       rxne,
    input logic       tc,
    input logic       tcr,
    input logic       nack_flag,
    input logic       stop_flag,
    input logic       arlo_flag,
    input logic       berr_flag,
    input logic       ovr_flag,
    input logic       eng_cmd_valid,
    input logic [1:0] eng_cmd,
    input logic       eng_arb_lost,
    input logic       eng_bus_err
);
    // R2: commands only go out while a transfer is open
    a_r2_cmd_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |-> busy);

    // R3: a byte request persists until software supplies the byte
    a_r3_txis_holds: assert property (@(posedge clk) disable iff (!rst_n)
        txis && !tx_wr && !eng_arb_lost && !eng_bus_err |=> txis);

    // R5: transfer-complete waits for a software decision
    a_r5_tc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        tc && !start_req && !stop_req && !eng_arb_lost && !eng_bus_err |=> tc);

    // R6: a reload resumes without a fresh START
    a_r6_reload_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        tcr && nbytes_load |=> !(eng_cmd_valid && eng_cmd == 2'd0));

    // R8: a NACK is followed at once by a STOP command
    a_r8_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_flag) |-> eng_cmd_valid && eng_cmd == 2'd3);

    // R9: STOP completion closes the transfer
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> !busy);

    // R11: overrun only when the previous byte was still unread
    a_r11_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(rxne));

    // R13: arbitration loss and bus error drop straight to idle
    a_r13_arlo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arlo_flag) |-> !busy && !eng_cmd_valid);
    a_r13_berr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr_flag) |-> !busy && !eng_cmd_valid);
endmodule

bind i2cx_xfer_ctrl i2cx_xfer_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .nbytes_load(nbytes_load), .tx_wr(tx_wr), .busy(busy), .txis(txis),
    .rxne(rxne), .tc(tc), .tcr(tcr), .nack_flag(nack_flag), .stop_flag(stop_flag),
    .arlo_flag(arlo_flag), .berr_flag(berr_flag), .ovr_flag(ovr_flag),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
    .eng_arb_lost(eng_arb_lost), .eng_bus_err(eng_bus_err)
);

// File: tb/sim_i2cx_xfer_ctrl.sv
// Bench: behavioural engine model with an expected-command queue.
module sim_i2cx_xfer_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_addr = '0;
    logic       cfg_ten_bit = 1'b0, cfg_read = 1'b0, cfg_reload = 1'b0, cfg_autoend = 1'b0;
    logic [7:0] cfg_nbytes = '0;
    logic       start_req = 1'b0, stop_req = 1'b0, nbytes_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [4:0] flag_clr = '0;
    logic [7:0] rx_data, eng_wdata;
    logic       busy, txis, rxne, tc, tcr;
    logic       nack_flag, stop_flag, arlo_flag, berr_flag, ovr_flag;
    logic       eng_cmd_valid, eng_ack_out;
    logic [1:0] eng_cmd;
    logic       eng_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0, eng_bus_err = 1'b0;
    logic [7:0] eng_rdata = '0;

    always #10 clk = ~clk;  // 50 MHz

    i2cx_xfer_ctrl u0 (.*);

    int vec = 0, bad = 0, eng_vec = 0, eng_bad = 0;
    int exp_q[$];
    int txq[$];
    int got[$];
    int cmd_idx = 0, cur_idx = 0, eng_cnt = 0;
    int inj_nack_at = -1, inj_arb_at = -1, inj_berr_at = -1;
    logic [7:0] rd_next = 8'h30, rd_val = 8'h00;
    int e_front, act;

    function automatic int enc(int c, int a, int d);
        return (c << 9) | (a << 8) | d;
    endfunction

    // Engine model: accepts a command, answers three cycles later, and
    // compares every accepted command with the expected queue (R2,R4,R5,R6,R12).
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_cnt <= 0; eng_done <= 1'b0; eng_nack <= 1'b0;
            eng_arb_lost <= 1'b0; eng_bus_err <= 1'b0;
        end else begin
            eng_done <= 1'b0; eng_nack <= 1'b0;
            eng_arb_lost <= 1'b0; eng_bus_err <= 1'b0;
            if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) begin
                    if (cur_idx == inj_arb_at)       eng_arb_lost <= 1'b1;
                    else if (cur_idx == inj_berr_at) eng_bus_err <= 1'b1;
                    else begin
                        eng_done  <= 1'b1;
                        eng_nack  <= (cur_idx == inj_nack_at);
                        eng_rdata <= rd_val;
                    end
                end
            end else if (eng_cmd_valid && !eng_done && !eng_arb_lost && !eng_bus_err) begin
                act = enc(int'(eng_cmd), (eng_cmd == 2'd2) ? int'(eng_ack_out) : 0,
                          (eng_cmd == 2'd1) ? int'(eng_wdata) : 0);
                eng_vec++;
                if (exp_q.size() == 0) begin
                    eng_bad++;
                    $display("FAIL R2 command stream: actual %0h expected none", act);
                end else begin
                    e_front = exp_q.pop_front();
                    if (e_front != act) begin
                        eng_bad++;
                        $display("FAIL R2 command stream: actual %0h expected %0h", act, e_front);
                    end
                end
                cur_idx <= cmd_idx;
                cmd_idx <= cmd_idx + 1;
                eng_cnt <= 3;
                if (eng_cmd == 2'd2) begin
                    rd_val  <= rd_next;
                    rd_next <= rd_next + 8'd1;
                end
            end
        end
    end

    // Per-clock consistency: no command outside an open transfer (R2).
    always @(negedge clk) begin
        if (rst_n && eng_cmd_valid && !busy) begin
            eng_bad++;
            $display("FAIL R2 command while idle: actual 1 expected 0");
        end
    end

    task automatic chk(input string tag, input int a, input int e);
        vec++;
        if (a != e) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, a, e);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec + eng_vec, bad + eng_bad);
    endtask

    task automatic do_start(input int a, input bit ten, input bit rd, input int n,
                            input bit rl, input bit ae);
        @(negedge clk);
        cfg_addr = a[9:0]; cfg_ten_bit = ten; cfg_read = rd;
        cfg_nbytes = n[7:0]; cfg_reload = rl; cfg_autoend = ae; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic do_clr(input logic [4:0] bits);
        @(negedge clk); flag_clr = bits;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Serve byte requests until the transfer closes or pauses.
    task automatic serve(input bit auto_rd);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            tx_wr = 1'b0; rx_rd = 1'b0;
            if (!busy || tc || tcr) return;
            if (txis) begin
                tx_data = txq.pop_front();
                tx_wr = 1'b1;
            end
            if (rxne && auto_rd) begin
                got.push_back(int'(rx_data));
                rx_rd = 1'b1;
            end
        end
        chk("serve timeout R3", 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 flags", {txis, rxne, tc, tcr, nack_flag, stop_flag, arlo_flag,
                         berr_flag, ovr_flag}, 0);
        chk("R1 cmd_valid", eng_cmd_valid, 0);

        // R2 R3 R7 R9: 7-bit write of three bytes, automatic STOP
        exp_q = {enc(0,0,0), enc(1,0,'hA0), enc(1,0,'h11), enc(1,0,'h22),
                 enc(1,0,'h33), enc(3,0,0)};
        txq = {'h11, 'h22, 'h33};
        do_start('h50, 0, 0, 3, 0, 1);
        serve(1);
        chk("R9 stop_flag", stop_flag, 1);
        chk("R9 busy", busy, 0);
        chk("R7 tc never set", tc, 0);
        chk("R3 all bytes written", exp_q.size() + txq.size(), 0);
        do_clr(5'b00010);
        chk("R13 stop clear", stop_flag, 0);

        // R4 R5: read three bytes, no automatic STOP
        got.delete();
        exp_q = {enc(0,0,0), enc(1,0,'h79), enc(2,0,0), enc(2,0,0), enc(2,1,0)};
        do_start('h3C, 0, 1, 3, 0, 0);
        serve(1);
        chk("R5 tc", tc, 1);
        idle(10);
        chk("R5 busy held", busy, 1);
        chk("R5 no command while tc", exp_q.size(), 0);
        chk("R4 byte count", got.size(), 3);
        if (got.size() == 3) begin
            chk("R4 byte0", got[0], 'h30);
            chk("R4 byte1", got[1], 'h31);
            chk("R4 byte2", got[2], 'h32);
        end
        chk("R4 rxne cleared", rxne, 0);
        exp_q = {enc(3,0,0)};
        do_stop();
        serve(1);
        chk("R5 stop after request", stop_flag, 1);
        do_clr(5'b00010);

        // R6: reload chunk of two, then a final chunk of one with automatic STOP
        exp_q = {enc(0,0,0), enc(1,0,'h24), enc(1,0,'hA1), enc(1,0,'hA2)};
        txq = {'hA1, 'hA2, 'hA3};
        do_start('h12, 0, 0, 2, 1, 0);
        serve(1);
        chk("R6 tcr", tcr, 1);
        idle(8);
        chk("R6 paused quiet", exp_q.size(), 0);
        exp_q = {enc(1,0,'hA3), enc(3,0,0)};
        @(negedge clk);
        cfg_nbytes = 8'd1; cfg_reload = 1'b0; cfg_autoend = 1'b1; nbytes_load = 1'b1;
        @(negedge clk);
        nbytes_load = 1'b0;
        serve(1);
        chk("R6 resumed and ended", exp_q.size() + txq.size(), 0);
        chk("R9 stop after reload chain", stop_flag, 1);
        do_clr(5'b00010);

        // R8: NACK on the second data byte
        inj_nack_at = cmd_idx + 3;
        exp_q = {enc(0,0,0), enc(1,0,'h40), enc(1,0,'h5A), enc(1,0,'h5B), enc(3,0,0)};
        txq = {'h5A, 'h5B, 'h5C};
        do_start('h20, 0, 0, 3, 0, 1);
        serve(1);
        chk("R8 nack_flag", nack_flag, 1);
        chk("R8 stop issued", stop_flag, 1);
        chk("R8 third byte not requested", txq.size(), 1);
        chk("R8 stream done", exp_q.size(), 0);
        txq.delete();
        do_clr(5'b00011);
        chk("R13 nack clear", nack_flag, 0);

        // R10 R5: zero-length write, then repeated START into a one-byte write
        exp_q = {enc(0,0,0), enc(1,0,'h88)};
        do_start('h44, 0, 0, 0, 0, 0);
        serve(1);
        chk("R10 tc after address only", tc, 1);
        chk("R10 address only", exp_q.size(), 0);
        exp_q = {enc(0,0,0), enc(1,0,'h8A), enc(1,0,'h77), enc(3,0,0)};
        txq = {'h77};
        do_start('h45, 0, 0, 1, 0, 1);
        serve(1);
        chk("R5 restart transfer", exp_q.size() + txq.size(), 0);
        chk("R5 restart stop", stop_flag, 1);
        do_clr(5'b00010);

        // R11: two bytes received with no read in between
        exp_q = {enc(0,0,0), enc(1,0,'h11), enc(2,0,0), enc(2,1,0), enc(3,0,0)};
        do_start('h08, 0, 1, 2, 0, 1);
        serve(0);
        chk("R11 ovr_flag", ovr_flag, 1);
        chk("R11 rxne", rxne, 1);
        chk("R11 newest byte kept", rx_data, 'h34);
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        chk("R4 read clears rxne", rxne, 0);
        do_clr(5'b10010);
        chk("R13 ovr clear", ovr_flag, 0);

        // R12: 10-bit read of one byte
        got.delete();
        exp_q = {enc(0,0,0), enc(1,0,'hF4), enc(1,0,'hA5), enc(0,0,0),
                 enc(1,0,'hF5), enc(2,1,0), enc(3,0,0)};
        do_start('h2A5, 1, 1, 1, 0, 1);
        serve(1);
        chk("R12 sequence", exp_q.size(), 0);
        chk("R12 byte", (got.size() == 1) ? got[0] : -1, 'h35);
        do_clr(5'b00010);

        // R13: arbitration lost during the address byte
        inj_arb_at = cmd_idx + 1;
        exp_q = {enc(0,0,0), enc(1,0,'h66)};
        txq = {'h99};
        do_start('h33, 0, 0, 1, 0, 1);
        serve(1);
        idle(5);
        chk("R13 arlo_flag sticky", arlo_flag, 1);
        chk("R13 no stop on arb loss", stop_flag, 0);
        chk("R13 idle after arb loss", busy, 0);
        chk("R13 arb stream", exp_q.size(), 0);
        txq.delete();
        do_clr(5'b00100);
        chk("R13 arlo clear", arlo_flag, 0);

        // R13: bus error during the address byte
        inj_berr_at = cmd_idx + 1;
        exp_q = {enc(0,0,0), enc(1,0,'h66)};
        txq = {'h98};
        do_start('h33, 0, 0, 1, 0, 1);
        serve(1);
        chk("R13 berr_flag", berr_flag, 1);
        chk("R13 idle after bus error", busy, 0);
        chk("R13 no stop on bus error", stop_flag, 0);
        txq.delete();
        do_clr(5'b01000);
        chk("R13 berr clear", berr_flag, 0);
        chk("R13 stream empty", exp_q.size(), 0);

        idle(4);
        summary();
        $finish;
    end
endmodule